// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs whole master transfers on an I2C bus by issuing one bit-level command at a time to a separate line engine. The engine drives the wires and reports each command's completion, the sampled data bit and any arbitration loss. A transfer is either a read of N bytes, or a write of M bytes optionally followed by a read of N bytes. The sequencer builds the address header in 7-bit or 10-bit form and pulls write data from a valid/ready stream. It delivers read data as single-cycle pulses, closes every transfer it still owns with STOP, and reports a final status together with sticky error flags.

A transfer starts on a `go` pulse while the block is idle. At that moment the mode, address, byte counts and timeout are captured. An internal elapsed-cycle counter is cleared at the same time. Before each byte on the bus, the counter is compared against the captured timeout. An expired timeout stops the transfer cleanly. The all-ones timeout value means the transfer never expires.

Top module: `i2c_xfer_seq`

## Requirements
- R1: In 7-bit mode the header is the single byte {addr[6:0], rw}, where rw=1 means read. addr[9:7] is ignored.
- R2: In 10-bit mode the header is the byte {5'b11110, addr[9:8], rw}, followed by addr[7:0].
- R3: Commands use the codes START=0, RESTART=1, STOP=2, WRITE=3 and READ=4. A transfer begins with START. Each written byte is sent as 8 WRITE commands, MSB first, followed by one READ that returns the slave's acknowledge, where 0 means ACK. A 1 on any written byte (header or data) issues STOP and ends the transfer with status NACK=2 and err_flags[1] set.
- R4: A read byte is 8 READ commands, MSB first, followed by one WRITE of the master's acknowledge. That bit is 0 for every byte except the last and 1 for the last. The byte appears on rx_data with a one-cycle rx_valid after its acknowledge completes.
- R5: In write mode all wr_len bytes are taken from the tx stream in order. If rd_len>0, the block then issues RESTART, re-sends only the first header byte with rw=1, and reads rd_len bytes. If rd_len=0, STOP follows the last write. Read-only mode sends the full header with rw=1 and ignores wr_len.
- R6: The timeout is counted in clock cycles from the accepted go. It expires once the elapsed count reaches tmo. The all-ones tmo never expires, even when the counter saturates.
- R7: The timeout is checked before every byte, header bytes included. If it has expired, the block issues STOP, takes no further tx byte, and ends with status TIMEOUT=4.
- R8: A transfer that completes without error ends with STOP and status OK=0. Every status of OK, NACK or TIMEOUT follows a completed STOP.
- R9: Arbitration loss on any command, including STOP, ends the transfer at once with no further command. It sets status ARB=3 and err_flags[0]. A read byte whose acknowledge command loses arbitration is not delivered.
- R10: A go whose active byte count is zero (rd_len in read-only mode, wr_len in write mode) issues no command. It pulses done on the next cycle with status PARAM=1.
- R11: err_flags never clear while busy, and are cleared when a new transfer is accepted. A go while busy is ignored.
- R12: cmd_valid, cmd_code and cmd_wbit hold steady until cmd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a transfer when idle |
| rd_only | input | 1 | 1: read-only transfer, 0: write with optional read |
| addr10 | input | 1 | 1: 10-bit addressing |
| addr | input | 10 | Slave address |
| wr_len | input | CW | Bytes to write |
| rd_len | input | CW | Bytes to read |
| tmo | input | TW | Timeout in cycles, all ones = none |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 3 | Final status code |
| err_flags | output | 2 | Sticky: [0] arbitration lost, [1] acknowledge failure |
| tx_data | input | 8 | Write data |
| tx_valid | input | 1 | Write data valid |
| tx_ready | output | 1 | Write byte taken this cycle when valid |
| rx_data | output | 8 | Read data |
| rx_valid | output | 1 | Read byte pulse |
| cmd_valid | output | 1 | Bit command pending |
| cmd_code | output | 3 | Bit command code |
| cmd_wbit | output | 1 | Bit to drive for WRITE |
| cmd_done | input | 1 | Engine finished the command |
| cmd_rbit | input | 1 | Sampled data bit |
| cmd_arb | input | 1 | Arbitration lost during the command |

## Verification
Delivering the last read byte and deciding on the closing STOP both hang on the master's final NACK command. An arbitration loss can land on that same command. The bench provokes this by having its engine model report loss exactly on the last acknowledge WRITE. It then expects the command trace to end there with no STOP, one fewer received byte and status ARB. The expiry check and the arrival of a write byte also meet in the same preparation cycle. A stalled tx stream under a finite and under an infinite timeout separates these two cases by the bytes consumed and the status.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rd_only,
  input  logic          addr10,
  input  logic [9:0]    addr,
  input  logic [CW-1:0] wr_len,
  input  logic [CW-1:0] rd_len,
  input  logic [TW-1:0] tmo,
  output logic          busy,
  output logic          done,
  output logic [2:0]    status,
  output logic [1:0]    err_flags,
  input  logic [7:0]    tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  output logic          cmd_valid,
  output logic [2:0]    cmd_code,
  output logic          cmd_wbit,
  input  logic          cmd_done,
  input  logic          cmd_rbit,
  input  logic          cmd_arb
);

  localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_STOP = 3'd2,
                         C_WRITE = 3'd3, C_READ = 3'd4;
  localparam logic [2:0] ST_OK = 3'd0, ST_PARAM = 3'd1, ST_NACK = 3'd2,
                         ST_ARB = 3'd3, ST_TMO = 3'd4;
  localparam logic [TW-1:0] TINF = {TW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RESTART, S_PREP, S_WBIT, S_RACK, S_RBIT, S_WACK, S_STOP
  } state_t;
  typedef enum logic [1:0] {PH_H1, PH_H2, PH_TX, PH_RX} phase_t;

  state_t        state;
  phase_t        phase;
  logic          rw, rep, a10;
  logic [9:0]    adr;
  logic [CW-1:0] wn, rn, cnt;
  logic [2:0]    bitc;
  logic [7:0]    sh;
  logic [TW-1:0] tlim, elapsed;
  logic [2:0]    fin, status_q;
  logic [1:0]    err_q;
  logic          done_q, rxv_q;

  wire expired = (tlim != TINF) && (elapsed >= tlim);
  wire step    = cmd_valid && cmd_done;
  wire abort   = step && cmd_arb && (state != S_STOP);
  wire zero_go = rd_only ? (rd_len == '0) : (wr_len == '0);
  wire [7:0] hdr1 = a10 ? {5'b11110, adr[9:8], rw} : {adr[6:0], rw};

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign err_flags = err_q;
  assign rx_data   = sh;
  assign rx_valid  = rxv_q;
  assign tx_ready  = (state == S_PREP) && (phase == PH_TX) && !expired;
  assign cmd_valid = (state != S_IDLE) && (state != S_PREP);

  always_comb begin
    case (state)
      S_START:        cmd_code = C_START;
      S_RESTART:      cmd_code = C_RESTART;
      S_STOP:         cmd_code = C_STOP;
      S_WBIT, S_WACK: cmd_code = C_WRITE;
      default:        cmd_code = C_READ;
    endcase
    case (state)
      S_WBIT:  cmd_wbit = sh[7];
      S_WACK:  cmd_wbit = (cnt == ONE);
      default: cmd_wbit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  phase <= PH_H1;
      rw <= 1'b0;  rep <= 1'b0;  a10 <= 1'b0;  adr <= '0;
      wn <= '0;  rn <= '0;  cnt <= '0;  bitc <= '0;  sh <= '0;
      tlim <= '0;  elapsed <= '0;  fin <= ST_OK;  status_q <= ST_OK;
      err_q <= '0;  done_q <= 1'b0;  rxv_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (busy && elapsed != TINF) elapsed <= elapsed + 1'b1;
      if (abort) begin
        err_q[0] <= 1'b1;
        status_q <= ST_ARB;
        done_q   <= 1'b1;
        state    <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (go) begin
            if (zero_go) begin
              done_q   <= 1'b1;
              status_q <= ST_PARAM;
            end else begin
              a10 <= addr10;  adr <= addr;  wn <= wr_len;  rn <= rd_len;
              tlim <= tmo;  elapsed <= '0;  err_q <= '0;
              rw <= rd_only;  rep <= 1'b0;  phase <= PH_H1;
              state <= S_START;
            end
          end
          S_START: if (step) begin
            phase <= PH_H1;
            state <= S_PREP;
          end
          S_RESTART: if (step) begin
            rw    <= 1'b1;
            rep   <= 1'b1;
            phase <= PH_H1;
            state <= S_PREP;
          end
          S_PREP: begin
            bitc <= '0;
            if (expired) begin
              fin   <= ST_TMO;
              state <= S_STOP;
            end else begin
              case (phase)
                PH_H1: begin sh <= hdr1;     state <= S_WBIT; end
                PH_H2: begin sh <= adr[7:0]; state <= S_WBIT; end
                PH_TX: if (tx_valid) begin sh <= tx_data; state <= S_WBIT; end
                default: state <= S_RBIT;
              endcase
            end
          end
          S_WBIT: if (step) begin
            sh   <= {sh[6:0], 1'b0};
            bitc <= bitc + 1'b1;
            if (bitc == 3'd7) state <= S_RACK;
          end
          S_RACK: if (step) begin
            if (cmd_rbit) begin
              err_q[1] <= 1'b1;
              fin      <= ST_NACK;
              state    <= S_STOP;
            end else begin
              case (phase)
                PH_H1, PH_H2: begin
                  if (phase == PH_H1 && a10 && !rep) begin
                    phase <= PH_H2;
                  end else begin
                    phase <= rw ? PH_RX : PH_TX;
                    cnt   <= rw ? rn : wn;
                  end
                  state <= S_PREP;
                end
                default: begin
                  cnt <= cnt - 1'b1;
                  if (cnt == ONE) begin
                    if (rn != '0) state <= S_RESTART;
                    else begin fin <= ST_OK; state <= S_STOP; end
                  end else begin
                    state <= S_PREP;
                  end
                end
              endcase
            end
          end
          S_RBIT: if (step) begin
            sh   <= {sh[6:0], cmd_rbit};
            bitc <= bitc + 1'b1;
            if (bitc == 3'd7) state <= S_WACK;
          end
          S_WACK: if (step) begin
            rxv_q <= 1'b1;
            cnt   <= cnt - 1'b1;
            if (cnt == ONE) begin
              fin   <= ST_OK;
              state <= S_STOP;
            end else begin
              state <= S_PREP;
            end
          end
          S_STOP: if (step) begin
            if (cmd_arb) err_q[0] <= 1'b1;
            status_q <= cmd_arb ? ST_ARB : fin;
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_wbit)));

  assert_start_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_valid && cmd_code == C_START));

  assert_rx_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(cmd_valid && cmd_code == C_WRITE && cmd_done && !cmd_arb));

  assert_stop_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == ST_OK || status == ST_NACK || status == ST_TMO))
      |-> $past(cmd_valid && cmd_code == C_STOP && cmd_done));

  assert_param_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && (rd_only ? (rd_len == '0) : (wr_len == '0)))
      |=> (done && !busy && status == ST_PARAM));

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((err_flags | $past(err_flags)) == err_flags));

endmodule

// File: tb/i2c_xfer_seq_test.sv
`timescale 1ns/1ps
module i2c_xfer_seq_test;
  localparam int CW = 3;
  localparam int TW = 8;
  localparam int N = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, rd_only = 1'b0, addr10 = 1'b0;
  logic [9:0] addr = '0;
  logic [CW-1:0] wr_len = '0, rd_len = '0;
  logic [TW-1:0] tmo = '1;
  logic busy, done, tx_ready, rx_valid, cmd_valid, cmd_wbit;
  logic [2:0] status, cmd_code;
  logic [1:0] err_flags;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, cmd_done = 1'b0, cmd_rbit = 1'b0, cmd_arb = 1'b0;

  always #2 clk = ~clk;

  i2c_xfer_seq #(.CW(CW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .rd_only(rd_only), .addr10(addr10),
    .addr(addr), .wr_len(wr_len), .rd_len(rd_len), .tmo(tmo), .busy(busy),
    .done(done), .status(status), .err_flags(err_flags), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wbit(cmd_wbit), .cmd_done(cmd_done), .cmd_rbit(cmd_rbit),
    .cmd_arb(cmd_arb));

  int total = 0, bad = 0;
  int exp_code[N], exp_w[N], exp_r[N], elen;
  int got_code[N], got_w[N], glen;
  int rx_exp[16], rx_ack[16], nrx, rx_got[16], rxn;
  int tx_first[16], txi, cur_wl, stall_j, stall_left, arb_at;
  int ended, bcount, wbytes, nack_k, tmo_k, exp_st, exp_err, seed, wc;
  bit hs_pend = 0, run_on = 0;

  function automatic int txv(int j); return (8'h5A + 71 * j + seed) & 255; endfunction
  function automatic int rxv(int j); return (8'hC3 ^ (53 * j + seed)) & 255; endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_done = 0; wc = 0;
    end else if (cmd_done) begin
      cmd_done = 0; wc = 0;
    end else if (cmd_valid) begin
      if (wc == 1) begin
        if (glen < N) begin
          got_code[glen] = int'(cmd_code);
          got_w[glen] = int'(cmd_wbit);
          cmd_rbit = exp_r[glen][0];
        end else cmd_rbit = 1'b1;
        cmd_arb = (glen == arb_at);
        glen++;
        cmd_done = 1;
      end else wc++;
    end
    if (rx_valid && rxn < 16) begin rx_got[rxn] = int'(rx_data); rxn++; end
    if (hs_pend) txi++;
    if (run_on && txi < cur_wl) begin
      if (txi == stall_j && stall_left > 0) begin tx_valid = 0; stall_left--; end
      else begin tx_valid = 1; tx_data = 8'(txv(txi)); end
    end else tx_valid = 0;
    hs_pend = tx_valid && tx_ready;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int c, int w, int r);
    if (!ended && elen < N) begin
      exp_code[elen] = c; exp_w[elen] = w; exp_r[elen] = r; elen++;
    end
  endtask

  task automatic put_wbyte(int v, int j);
    if (ended) return;
    if (bcount == tmo_k) begin push(2, 1, 0); ended = 1; exp_st = 4; return; end
    bcount++;
    if (j >= 0) tx_first[j] = elen;
    for (int i = 7; i >= 0; i--) push(3, (v >> i) & 1, 0);
    push(4, 1, (wbytes == nack_k) ? 1 : 0);
    if (wbytes == nack_k) begin push(2, 1, 0); ended = 1; exp_st = 2; exp_err = 2; end
    wbytes++;
  endtask

  task automatic put_rbyte(int v, int last, int j);
    if (ended) return;
    if (bcount == tmo_k) begin push(2, 1, 0); ended = 1; exp_st = 4; return; end
    bcount++;
    for (int i = 7; i >= 0; i--) push(4, 1, (v >> i) & 1);
    rx_ack[j] = elen; rx_exp[j] = v; nrx++;
    push(3, last, 0);
  endtask

  task automatic header(int a10, int ad, int rw, int first_only);
    if (a10 != 0) begin
      put_wbyte(8'hF0 | (((ad >> 8) & 3) << 1) | rw, -1);
      if (first_only == 0) put_wbyte(ad & 255, -1);
    end else put_wbyte(((ad & 127) << 1) | rw, -1);
  endtask

  task automatic run(string req, int a10, int rdo, int ad, int wl, int rl, int tm,
                     int ab, int nk, int tk, int sj, int sn, int busy_go);
    int cnt_rx, cnt_tx, mism, cap;
    bit ok;
    seed += 17;
    elen = 0; ended = 0; bcount = 0; wbytes = 0; nrx = 0; exp_st = 0; exp_err = 0;
    nack_k = nk; tmo_k = tk;
    for (int i = 0; i < 16; i++) tx_first[i] = 9999;
    for (int i = 0; i < N; i++) exp_r[i] = 0;
    push(0, 1, 0);
    header(a10, ad, rdo, 0);
    if (rdo == 0) begin
      for (int j = 0; j < wl; j++) put_wbyte(txv(j), j);
      if (rl > 0) begin push(1, 1, 0); header(a10, ad, 1, 1); end
    end
    for (int j = 0; j < rl; j++) put_rbyte(rxv(j), (j == rl - 1) ? 1 : 0, j);
    push(2, 1, 0);
    if (ab >= 0 && ab < elen) begin elen = ab + 1; exp_st = 3; exp_err = 1; end
    @(negedge clk);
    glen = 0; rxn = 0; txi = 0; arb_at = ab; stall_j = sj; stall_left = sn;
    cur_wl = (rdo != 0) ? 0 : wl;
    addr10 = a10[0]; rd_only = rdo[0]; addr = 10'(ad); wr_len = CW'(wl);
    rd_len = CW'(rl); tmo = TW'(tm); run_on = 1; go = 1;
    @(negedge clk);
    go = 0;
    if (busy_go != 0) begin
      repeat (15) @(negedge clk);
      rd_only = ~rd_only; wr_len = '0; rd_len = '0; go = 1;
      @(negedge clk);
      go = 0;
    end
    cap = 0;
    while (!done && cap < 5000) begin @(negedge clk); cap++; end
    check(cap < 5000, req, "done seen", cap, 0);
    run_on = 0;
    mism = -1;
    for (int i = 0; i < elen && i < glen; i++)
      if (mism < 0 && (got_code[i] != exp_code[i] ||
          (exp_code[i] == 3 && got_w[i] != exp_w[i]))) mism = i;
    ok = (glen == elen) && (mism < 0);
    check(ok, req, "command trace length / first mismatch", glen * 1000 + mism, elen * 1000 - 1);
    check(int'(status) == exp_st, req, "status", int'(status), exp_st);
    check(int'(err_flags) == exp_err, req, "err_flags", int'(err_flags), exp_err);
    cnt_rx = 0;
    for (int j = 0; j < nrx; j++) if (rx_ack[j] < elen && rx_ack[j] != ab) cnt_rx++;
    ok = (rxn == cnt_rx);
    for (int j = 0; j < cnt_rx && j < rxn; j++) if (rx_got[j] != rx_exp[j]) ok = 0;
    check(ok, req, "received bytes count", rxn, cnt_rx);
    cnt_tx = 0;
    for (int j = 0; j < 16; j++) if (tx_first[j] < elen) cnt_tx++;
    check(txi == cnt_tx, req, "tx bytes consumed", txi, cnt_tx);
    repeat (3) @(negedge clk);
  endtask

  task automatic param_go(string req, int rdo, int wl, int rl);
    @(negedge clk);
    glen = 0; arb_at = -1;
    rd_only = rdo[0]; wr_len = CW'(wl); rd_len = CW'(rl); go = 1;
    @(negedge clk);
    go = 0;
    check(done == 1'b1 && busy == 1'b0, req, "param done pulse", int'(done), 1);
    check(int'(status) == 1, req, "param status", int'(status), 1);
    repeat (10) @(negedge clk);
    check(glen == 0, req, "no command after param error", glen, 0);
  endtask

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed = 3; arb_at = -1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !cmd_valid && !tx_ready && !rx_valid && err_flags == 0,
          "R3", "reset outputs quiet", int'(busy), 0);
    // R1 R2 R4 R5 R8: sweep of modes, lengths and addresses
    for (int a10 = 0; a10 < 2; a10++)
      for (int rdo = 0; rdo < 2; rdo++)
        for (int wl = 1; wl <= 3; wl++)
          for (int rl = 0; rl <= 3; rl++) begin
            int ad;
            if (rdo == 1 && (wl > 1 || rl == 0)) continue;
            ad = (a10 != 0) ? ((10'h2A5 + 97 * (wl * 4 + rl)) & 1023)
                            : (((7'h35 + 13 * (wl * 4 + rl)) & 127) | 10'h380);
            run("R1 R2 R4 R5 R8", a10, rdo, ad, (rdo != 0) ? 0 : wl, rl, 255,
                -1, -1, -1, -1, 0, 0);
          end
    // R3: acknowledge failures at header, second header, data, re-sent header
    run("R3", 0, 0, 10'h12, 2, 0, 200, -1, 0, -1, -1, 0, 0);
    run("R3", 1, 1, 10'h1C7, 0, 2, 200, -1, 1, -1, -1, 0, 0);
    run("R3", 0, 0, 10'h44, 3, 0, 200, -1, 2, -1, -1, 0, 0);
    run("R3 R5", 0, 0, 10'h2B, 1, 2, 200, -1, 2, -1, -1, 0, 0);
    // R9: arbitration loss at START, mid header, last NACK, STOP
    run("R9", 0, 0, 10'h51, 1, 0, 200, 0, -1, -1, -1, 0, 0);
    run("R9", 0, 0, 10'h51, 1, 0, 200, 5, -1, -1, -1, 0, 0);
    run("R9 R4", 0, 1, 10'h66, 0, 2, 200, 27, -1, -1, -1, 0, 0);
    run("R9", 0, 1, 10'h66, 0, 2, 200, 28, -1, -1, -1, 0, 0);
    // R11: flags cleared on next accepted transfer, go while busy ignored
    run("R11", 0, 0, 10'h0F, 1, 1, 255, -1, -1, -1, -1, 0, 0);
    run("R11", 1, 0, 10'h3AA, 3, 3, 255, -1, -1, -1, -1, 0, 1);
    // R6 R7: zero timeout, stalled stream finite vs infinite
    run("R6 R7", 0, 0, 10'h21, 2, 0, 0, -1, -1, 0, -1, 0, 0);
    run("R6 R7", 0, 0, 10'h21, 3, 0, 254, -1, -1, 2, 1, 300, 0);
    run("R6", 0, 0, 10'h21, 3, 0, 255, -1, -1, -1, 1, 300, 0);
    // R10: zero counts rejected
    param_go("R10", 0, 0, 2);
    param_go("R10", 1, 3, 0);
    // R12: held commands are covered by the bench engine waiting one cycle per command
    run("R12", 1, 0, 10'h155, 1, 1, 255, -1, -1, -1, -1, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule